// File: doc/BRIEF.md
# I2S Slave Transmit Frame Bridge

This block joins a synchronous serial port that frames its words with short sync pulses to an external audio codec that is the I2S master. The codec drives the bit clock and the word-select line. The bridge passes the bit clock to the serial port, inverted or not under a control input. It turns every word-select transition into a frame-sync pulse one bit period wide.

The serial port's transmit bitstream reaches the codec's data line through a delay pipe one frame long. A frame is two channel words. The codec therefore always hears the data one frame late. The codec line is held at 0 until a full frame of bits has entered the pipe since reset. A mode input chooses whether the sync pulse appears in the bit period right after the new word-select level is sampled, or one bit period later. The data lag does not depend on that choice.

All state is clocked by the codec bit clock `sck`. Input sampling, the word-select history and the pipe advance on rising edges. The codec data output changes on falling edges, so the codec can sample it on the next rising edge.

Top module: `i2s_tx_bridge`

## Requirements
- R1: `port_clk` equals `sck` when `clk_inv` is 0 and equals the inverse of `sck` when `clk_inv` is 1.
- R2: With `fs_early` = 1, `port_fs` is high for the bit period that follows the rising `sck` edge at which `ws` is first sampled at a new level. This holds for rising and for falling `ws` transitions.
- R3: With `fs_early` = 0, the pulse of R2 appears one bit period later, in the period that follows the next rising `sck` edge.
- R4: Each sync pulse is exactly one bit period wide. `port_fs` stays low while `ws` holds its level.
- R5: The bit sampled on `port_txd` at rising edge k (counted from 0 after reset) is driven on `codec_sd` from the falling edge after rising edge k+FRAME_BITS-1 until the next falling edge. FRAME_BITS is 2*CH_BITS. `codec_sd` never changes except on a falling `sck` edge, and the lag is the same for both values of `fs_early`.
- R6: Until FRAME_BITS rising edges have passed since reset, `codec_sd` is 0, whatever data was in the pipe before reset.
- R7: A synchronous reset (`rst` high at a rising edge) clears the stored word-select history to 0, the pipe and the fill count. It also drives `port_fs` and `codec_sd` to 0. A `ws` that is high at the first edge after reset counts as a transition and produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Bit clock from the codec; clocks all state |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word-select line from the codec |
| clk_inv | input | 1 | 1 inverts the clock passed to the serial port |
| fs_early | input | 1 | 1: sync pulse without the extra bit-period delay; 0: delayed one bit period |
| port_txd | input | 1 | Transmit bitstream from the serial port |
| port_clk | output | 1 | Conditioned bit clock to the serial port |
| port_fs | output | 1 | Frame-sync pulse to the serial port |
| codec_sd | output | 1 | Serial data to the codec |

## Verification
Each result has a fixed time. `port_fs` settles after the rising edge that samples the stimulus in early mode, and one rising edge later in delayed mode. `codec_sd` reflects the bit sampled at rising edge k from the falling edge after rising edge k+FRAME_BITS-1. `port_clk` follows `sck` at once.

Inputs are driven 2 ns after each rising edge. Results are sampled late in the low phase, just before the next rising edge, so every register on each path has updated. The codec output is also sampled in the high phase, to confirm that it moves only at falling edges.

The sweep covers both clock polarities, both pulse modes and three word-select patterns: regular channels, a high start after reset, and irregular short runs. It computes every expected value from the cycle index alone.

// File: rtl/i2s_txb_pkg.sv
package i2s_txb_pkg;

    // Word-select history, newest sample first.
    typedef struct packed {
        logic d1;
        logic d2;
        logic d3;
    } ws_hist_t;

    typedef enum logic {
        FS_LATE  = 1'b0,
        FS_EARLY = 1'b1
    } fs_mode_e;

    function automatic logic level_change(input logic a, input logic b);
        return a ^ b;
    endfunction

    function automatic int unsigned frame_len(input int unsigned ch_bits);
        return 2 * ch_bits;
    endfunction

endpackage

// File: rtl/txb_clk_cond.sv
module txb_clk_cond (
    input  logic sck,
    input  logic clk_inv,
    output logic port_clk
);
    assign port_clk = clk_inv ? ~sck : sck;
endmodule

// File: rtl/txb_ws_pulse.sv
module txb_ws_pulse
    import i2s_txb_pkg::*;
(
    input  logic sck,
    input  logic rst,
    input  logic ws,
    input  logic fs_early,
    output logic port_fs
);
    ws_hist_t hist;
    fs_mode_e mode;
    logic     pulse_now;
    logic     pulse_late;

    always_ff @(posedge sck) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist.d1 <= ws;
            hist.d2 <= hist.d1;
            hist.d3 <= hist.d2;
        end
    end

    assign mode       = fs_mode_e'(fs_early);
    assign pulse_now  = level_change(hist.d1, hist.d2);
    assign pulse_late = level_change(hist.d2, hist.d3);

    always_comb begin
        unique case (mode)
            FS_EARLY: port_fs = pulse_now;
            default:  port_fs = pulse_late;
        endcase
    end
endmodule

// File: rtl/txb_tx_delay.sv
module txb_tx_delay #(
    parameter int unsigned FRAME_BITS = 32
) (
    input  logic sck,
    input  logic rst,
    input  logic port_txd,
    output logic codec_sd
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] pipe;
    logic [CNT_W-1:0]      fill_cnt;
    logic                  full;

    generate
        if (FRAME_BITS == 1) begin : g_single
            always_ff @(posedge sck) begin
                if (rst) pipe <= '0;
                else     pipe <= port_txd;
            end
        end else begin : g_shift
            always_ff @(posedge sck) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[FRAME_BITS-2:0], port_txd};
            end
        end
    endgenerate

    always_ff @(posedge sck) begin
        if (rst)              fill_cnt <= '0;
        else if (!full)       fill_cnt <= fill_cnt + 1'b1;
    end

    assign full = (fill_cnt == FULL_CNT);

    always_ff @(negedge sck) begin
        if (rst)       codec_sd <= 1'b0;
        else if (full) codec_sd <= pipe[FRAME_BITS-1];
        else           codec_sd <= 1'b0;
    end
endmodule

// File: rtl/i2s_tx_bridge.sv
module i2s_tx_bridge
    import i2s_txb_pkg::*;
#(
    parameter int unsigned CH_BITS = 16
) (
    input  logic sck,
    input  logic rst,
    input  logic ws,
    input  logic clk_inv,
    input  logic fs_early,
    input  logic port_txd,
    output logic port_clk,
    output logic port_fs,
    output logic codec_sd
);
    localparam int unsigned FRAME_BITS = frame_len(CH_BITS);

    txb_clk_cond u_clk (
        .sck      (sck),
        .clk_inv  (clk_inv),
        .port_clk (port_clk)
    );

    txb_ws_pulse u_fs (
        .sck      (sck),
        .rst      (rst),
        .ws       (ws),
        .fs_early (fs_early),
        .port_fs  (port_fs)
    );

    txb_tx_delay #(
        .FRAME_BITS (FRAME_BITS)
    ) u_dly (
        .sck      (sck),
        .rst      (rst),
        .port_txd (port_txd),
        .codec_sd (codec_sd)
    );
endmodule

// File: rtl/i2s_tx_bridge_chk.sv
module i2s_tx_bridge_chk #(
    parameter int unsigned FRAME_BITS = 32
) (
    input logic sck,
    input logic rst,
    input logic ws,
    input logic clk_inv,
    input logic fs_early,
    input logic port_txd,
    input logic port_clk,
    input logic port_fs,
    input logic codec_sd
);
    localparam int unsigned NB_W = $clog2(FRAME_BITS + 1);

    logic [1:0]      seen;
    logic [NB_W-1:0] nb;

    always_ff @(posedge sck) begin
        if (rst) begin
            seen <= '0;
            nb   <= '0;
        end else begin
            if (seen != 2'd3) seen <= seen + 2'd1;
            if (nb != NB_W'(FRAME_BITS)) nb <= nb + 1'b1;
        end
    end

    // R1
    clk_pass_chk: assert property (@(posedge sck) disable iff (rst)
        port_clk == clk_inv);

    // R2
    early_pulse_chk: assert property (@(posedge sck) disable iff (rst)
        (fs_early && seen == 2'd3) |-> (port_fs == ($past(ws) != $past(ws, 2))));

    // R3
    late_pulse_chk: assert property (@(posedge sck) disable iff (rst)
        (!fs_early && seen == 2'd3) |-> (port_fs == ($past(ws, 2) != $past(ws, 3))));

    // R4
    pulse_width_chk: assert property (@(posedge sck) disable iff (rst)
        (fs_early && port_fs && seen != 2'd0 && ws == $past(ws)) |=> (!port_fs || !fs_early));

    // R6
    fill_zero_chk: assert property (@(posedge sck) disable iff (rst)
        (nb < NB_W'(FRAME_BITS)) |-> !codec_sd);

    // R7
    reset_quiet_chk: assert property (@(posedge sck) disable iff (rst)
        $past(rst) |-> (!port_fs && !codec_sd));
endmodule

bind i2s_tx_bridge i2s_tx_bridge_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (.*);

// File: tb/i2s_tx_bridge_test.sv
module i2s_tx_bridge_test;
    localparam int CH    = 16;
    localparam int FRAME = 2 * CH;
    localparam int N     = 160;

    logic sck = 1'b0;
    logic rst = 1'b1;
    logic ws = 1'b0;
    logic clk_inv = 1'b0;
    logic fs_early = 1'b0;
    logic port_txd = 1'b0;
    logic port_clk, port_fs, codec_sd;

    int checks = 0;
    int failures = 0;

    logic ws_v [N];
    logic tx_v [N];

    i2s_tx_bridge #(.CH_BITS(CH)) uut (
        .sck(sck), .rst(rst), .ws(ws), .clk_inv(clk_inv), .fs_early(fs_early),
        .port_txd(port_txd), .port_clk(port_clk), .port_fs(port_fs), .codec_sd(codec_sd)
    );

    always #4 sck = ~sck;

    task automatic chk(input string req, input logic act, input logic exp, input int cyc);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    function automatic logic wsat(input int i);
        return (i >= 0) ? ws_v[i] : 1'b0;
    endfunction

    task automatic build(input int pat, inout logic [15:0] lf);
        int  run;
        logic lvl;
        run = 0;
        lvl = 1'b0;
        for (int c = 0; c < N; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            tx_v[c] = lf[0];
            case (pat)
                0: ws_v[c] = ((c / CH) % 2) != 0;
                1: ws_v[c] = ((c / CH) % 2) == 0;
                default: begin
                    if (run == 0) begin
                        lvl = ~lvl;
                        run = 2 + int'(lf[3:2]);
                    end
                    run--;
                    ws_v[c] = lvl;
                end
            endcase
        end
    endtask

    task automatic run_cfg(input logic inv, input logic early, input int pat, inout logic [15:0] lf);
        logic prev_sd;
        build(pat, lf);
        @(posedge sck); #2;
        rst = 1'b1; clk_inv = inv; fs_early = early; ws = 1'b1; port_txd = 1'b1;
        @(posedge sck);
        @(posedge sck); #5;
        // R7: outputs quiet while reset is applied
        chk("R7 reset fs", port_fs, 1'b0, -1);
        chk("R7 reset sd", codec_sd, 1'b0, -1);
        @(posedge sck); #2;
        rst = 1'b0; ws = ws_v[0]; port_txd = tx_v[0];
        prev_sd = 1'b0;
        for (int c = 0; c < N; c++) begin
            logic efs, esd;
            @(posedge sck); #2;
            chk("R1 high phase", port_clk, ~inv, c);
            chk("R5 sd held over rising edge", codec_sd, prev_sd, c);
            if (c + 1 < N) begin
                ws = ws_v[c + 1];
                port_txd = tx_v[c + 1];
            end
            #5;
            chk("R1 low phase", port_clk, inv, c);
            efs = early ? (wsat(c) ^ wsat(c - 1)) : (wsat(c - 1) ^ wsat(c - 2));
            chk(early ? "R2 early pulse" : "R3 late pulse", port_fs, efs, c);
            esd = (c >= FRAME - 1) ? tx_v[c - FRAME + 1] : 1'b0;
            chk((c < FRAME - 1) ? "R6 zero fill" : "R5 frame lag", codec_sd, esd, c);
            prev_sd = codec_sd;
        end
    endtask

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int pat = 0; pat < 3; pat++) begin
                run_cfg(cfg[0], cfg[1], pat, lf);
            end
        end
        // R4: steady ws after the sweep gives no pulse
        ws = ws_v[N - 1];
        for (int k = 0; k < 6; k++) begin
            @(posedge sck); #7;
            if (k >= 2) chk("R4 steady ws no pulse", port_fs, 1'b0, k);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule